// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Steering

This block sits between an instruction queue and a reorder buffer. Each cycle it looks at a window of up to three instructions, oldest first. Each instruction carries a tag and a micro-op count that has already been worked out. The block picks the longest in-order group that its decode slots can take. The oldest instruction always lands in the complex slot, which can produce up to four micro-ops. The two simple slots behind it take only instructions that need exactly one micro-op.

The micro-ops of an accepted group are written in program order into a six-entry micro-op queue. The queue hands up to three micro-ops per cycle to the consumer. Each micro-op carries its instruction's tag, its position within that instruction, and a flag that marks the final micro-op of the instruction.

Both data edges use a valid/ready rule. On the input side, the window in `in_valid` must be a contiguous run starting at slot 0. The block answers in the same cycle with `in_take`, the number of leading instructions it consumed, and the producer must drop exactly that many before the next cycle. A `in_take` of zero is back-pressure, and the window must then be presented again unchanged or refilled. On the output side, `out_valid` shows the oldest queued micro-ops as a contiguous run from lane 0. When `out_ready` is high at a clock edge, every lane shown is removed. When `out_ready` is low, nothing is removed.

Top module: `ds_decode_steer`

## Requirements
- R1: After reset the micro-op queue is empty: `out_valid` is 0. With no valid input, `in_take` and `dec_err` are 0.
- R2: The oldest valid instruction with a legal count n (1 to 4) yields n micro-ops with its tag. Their sequence numbers are 0 to n-1 and the last flag is set only on the one numbered n-1. An instruction taken in a simple slot yields one micro-op with sequence 0 and the last flag set.
- R3: The instructions in window slots 1 and 2 join the group in order, and only while each one has a count of exactly 1. The first one that does not qualify ends the group, and it is presented as the oldest instruction in the next window.
- R4: One cycle accepts at most three instructions and at most six micro-ops. A group of a four-micro-op instruction followed by two single-micro-op instructions is accepted whole when the queue is empty.
- R5: A group is accepted only if its micro-op total is no larger than the free entries, which are six minus the occupancy before this cycle's removal. Otherwise `in_take` is 0 and nothing is written.
- R6: If the oldest valid instruction has a count of 0 or of 5 to 7, `dec_err` is high, `in_take` is 0 and no micro-op is written.
- R7: The output shows min(occupancy, 3) micro-ops as a contiguous run from lane 0. With `out_ready` high they are all removed at the edge. With `out_ready` low the queue keeps them all.
- R8: `in_take` never exceeds the run of valid window slots. A window slot with `in_valid` low ends the group even if later slots are valid.
- R9: Micro-ops leave the queue in exactly the order in which the instructions were accepted, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Window slot valid bits, slot 0 oldest, contiguous from slot 0 |
| in_cnt | input | 9 | Micro-op count per slot, 3 bits each, slot k at bits [3k+2:3k] |
| in_tag | input | 24 | Instruction tag per slot, 8 bits each, slot k at bits [8k+7:8k] |
| in_take | output | 2 | Number of leading window instructions consumed this cycle |
| dec_err | output | 1 | Oldest instruction has an illegal micro-op count and is held |
| out_valid | output | 3 | Output lane valid bits, lane 0 oldest |
| out_ready | input | 1 | Consumer removes all shown lanes at the clock edge |
| out_tag | output | 24 | Tag per output lane, 8 bits each |
| out_seq | output | 6 | Micro-op index within its instruction, 2 bits per lane |
| out_last | output | 3 | Set on the final micro-op of an instruction, one bit per lane |

## Verification
The bench targets the grouping cut. A later instruction needing two or more micro-ops, a zero count in a later slot, or a hole in the valid bits must all end the group. A design that let any of these through would consume an instruction that no slot can decode. Space checks are driven at the edge, where the queue is one entry short of a group. A design that accounted for the same-cycle removal, or that took a partial group, would report the wrong `in_take` and push micro-ops the model never expected. Illegal counts are held at the head for several cycles. Queue wrap-around under a stalled and then alternating consumer exposes pointer or ordering mistakes as tag, sequence or last-flag mismatches in the scoreboard.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int DS_TAG_W    = 8;
  localparam int DS_CNT_W    = 3;
  localparam int DS_CPLX_MAX = 4;
  localparam int DS_SEQ_W    = $clog2(DS_CPLX_MAX);

  typedef struct packed {
    logic [DS_TAG_W-1:0] tag;
    logic [DS_SEQ_W-1:0] seq;
    logic                last;
  } uop_t;

  // legal counts are 1..DS_CPLX_MAX
  function automatic logic cnt_legal(input logic [DS_CNT_W-1:0] c);
    return (c != '0) && (int'(c) <= DS_CPLX_MAX);
  endfunction
endpackage

// File: rtl/ds_group.sv
module ds_group
  import ds_pkg::*;
#(
  parameter int NSLOT  = 3,
  parameter int QCNT_W = 3,
  parameter int PUSH_W = 3,
  parameter int TAKE_W = 2
) (
  input  logic [NSLOT-1:0]                slot_vld,
  input  logic [NSLOT-1:0][DS_CNT_W-1:0]  slot_cnt,
  input  logic [QCNT_W-1:0]               q_free,
  output logic [TAKE_W-1:0]               take_n,
  output logic [PUSH_W-1:0]               grp_uops,
  output logic                            head_bad
);

  always_comb begin : pick
    logic              open;
    logic [TAKE_W-1:0] n;
    logic [PUSH_W-1:0] u;
    head_bad = slot_vld[0] && !cnt_legal(slot_cnt[0]);
    n    = '0;
    u    = '0;
    open = 1'b0;
    // oldest instruction always goes to the complex slot
    if (slot_vld[0] && !head_bad) begin
      n    = TAKE_W'(1);
      u    = PUSH_W'(slot_cnt[0]);
      open = 1'b1;
    end
    // simple slots accept single-micro-op instructions, in order
    for (int k = 1; k < NSLOT; k++) begin
      if (open && slot_vld[k] && slot_cnt[k] == DS_CNT_W'(1)) begin
        n = n + TAKE_W'(1);
        u = u + PUSH_W'(1);
      end else begin
        open = 1'b0;
      end
    end
    // whole group or nothing
    if (int'(u) <= int'(q_free)) begin
      take_n   = n;
      grp_uops = u;
    end else begin
      take_n   = '0;
      grp_uops = '0;
    end
  end

endmodule

// File: rtl/ds_expand.sv
module ds_expand
  import ds_pkg::*;
#(
  parameter int NSLOT    = 3,
  parameter int PUSH_MAX = 6
) (
  input  logic [NSLOT-1:0][DS_CNT_W-1:0] slot_cnt,
  input  logic [NSLOT-1:0][DS_TAG_W-1:0] slot_tag,
  output uop_t [PUSH_MAX-1:0]            lane_uop
);

  // lanes 0..c0-1 carry the complex slot; the following lanes carry
  // the simple slots in order. Lanes past the group are never written.
  always_comb begin : lanes
    int c0;
    int s;
    c0 = int'(slot_cnt[0]);
    for (int j = 0; j < PUSH_MAX; j++) begin
      lane_uop[j] = '0;
      s = j - c0 + 1;
      if (j < c0) begin
        lane_uop[j].tag  = slot_tag[0];
        lane_uop[j].seq  = DS_SEQ_W'(j);
        lane_uop[j].last = (j == c0 - 1);
      end else if (s > 0 && s < NSLOT) begin
        lane_uop[j].tag  = slot_tag[s];
        lane_uop[j].last = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ds_uopq.sv
module ds_uopq
  import ds_pkg::*;
#(
  parameter int QDEPTH   = 6,
  parameter int PUSH_MAX = 6,
  parameter int POP_MAX  = 3,
  parameter int QCNT_W   = 3,
  parameter int PUSH_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PUSH_W-1:0]     push_n,
  input  uop_t [PUSH_MAX-1:0]   push_uop,
  input  logic                  pop_req,
  output logic [QCNT_W-1:0]     q_cnt,
  output uop_t [POP_MAX-1:0]    out_uop,
  output logic [POP_MAX-1:0]    out_vld
);

  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  uop_t              mem [QDEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [QCNT_W-1:0] cnt;
  logic [QCNT_W-1:0] pop_n;

  function automatic logic [PTR_W-1:0] wrap(input int p);
    return PTR_W'(p % QDEPTH);
  endfunction

  always_comb begin
    if (!pop_req)                pop_n = '0;
    else if (int'(cnt) > POP_MAX) pop_n = QCNT_W'(POP_MAX);
    else                         pop_n = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wrap(int'(wr_ptr) + int'(push_n));
      rd_ptr <= wrap(int'(rd_ptr) + int'(pop_n));
      cnt    <= cnt + QCNT_W'(push_n) - pop_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < PUSH_MAX; j++) begin
      if (rst_n && j < int'(push_n)) mem[wrap(int'(wr_ptr) + j)] <= push_uop[j];
    end
  end

  always_comb begin
    for (int i = 0; i < POP_MAX; i++) begin
      out_uop[i] = mem[wrap(int'(rd_ptr) + i)];
      out_vld[i] = (i < int'(cnt));
    end
  end

  assign q_cnt = cnt;

  // R5: the steering side never writes more than the free entries
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(push_n) <= QDEPTH - int'(q_cnt));

endmodule

// File: rtl/ds_decode_steer.sv
module ds_decode_steer
  import ds_pkg::*;
#(
  parameter int NSLOT   = 3,
  parameter int QDEPTH  = 6,
  parameter int POP_MAX = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSLOT-1:0]              in_valid,
  input  logic [NSLOT*DS_CNT_W-1:0]     in_cnt,
  input  logic [NSLOT*DS_TAG_W-1:0]     in_tag,
  output logic [$clog2(NSLOT+1)-1:0]    in_take,
  output logic                          dec_err,
  output logic [POP_MAX-1:0]            out_valid,
  input  logic                          out_ready,
  output logic [POP_MAX*DS_TAG_W-1:0]   out_tag,
  output logic [POP_MAX*DS_SEQ_W-1:0]   out_seq,
  output logic [POP_MAX-1:0]            out_last
);

  localparam int TAKE_W   = $clog2(NSLOT + 1);
  localparam int PUSH_MAX = DS_CPLX_MAX + NSLOT - 1;
  localparam int PUSH_W   = $clog2(PUSH_MAX + 1);
  localparam int QCNT_W   = $clog2(QDEPTH + 1);

  logic [NSLOT-1:0][DS_CNT_W-1:0] cnt_a;
  logic [NSLOT-1:0][DS_TAG_W-1:0] tag_a;
  logic [QCNT_W-1:0]              q_cnt;
  logic [QCNT_W-1:0]              q_free;
  logic [PUSH_W-1:0]              grp_uops;
  uop_t [PUSH_MAX-1:0]            lane_uop;
  uop_t [POP_MAX-1:0]             head_uop;

  assign cnt_a  = in_cnt;
  assign tag_a  = in_tag;
  assign q_free = QCNT_W'(QDEPTH) - q_cnt;

  ds_group #(
    .NSLOT(NSLOT), .QCNT_W(QCNT_W), .PUSH_W(PUSH_W), .TAKE_W(TAKE_W)
  ) u_group (
    .slot_vld (in_valid),
    .slot_cnt (cnt_a),
    .q_free   (q_free),
    .take_n   (in_take),
    .grp_uops (grp_uops),
    .head_bad (dec_err)
  );

  ds_expand #(
    .NSLOT(NSLOT), .PUSH_MAX(PUSH_MAX)
  ) u_expand (
    .slot_cnt (cnt_a),
    .slot_tag (tag_a),
    .lane_uop (lane_uop)
  );

  ds_uopq #(
    .QDEPTH(QDEPTH), .PUSH_MAX(PUSH_MAX), .POP_MAX(POP_MAX),
    .QCNT_W(QCNT_W), .PUSH_W(PUSH_W)
  ) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (grp_uops),
    .push_uop (lane_uop),
    .pop_req  (out_ready),
    .q_cnt    (q_cnt),
    .out_uop  (head_uop),
    .out_vld  (out_valid)
  );

  for (genvar i = 0; i < POP_MAX; i++) begin : g_out
    assign out_tag[i*DS_TAG_W +: DS_TAG_W] = head_uop[i].tag;
    assign out_seq[i*DS_SEQ_W +: DS_SEQ_W] = head_uop[i].seq;
    assign out_last[i]                     = head_uop[i].last;
  end

  // R6: an illegal head is never consumed
  a_r6_err_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> in_take == '0);

  // R8: consumption stays inside the valid window
  a_r8_take_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    int'(in_take) <= $countones(in_valid));

  // R7: output lanes form a run from lane 0
  a_r7_out_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid + 1'b1) & out_valid) == '0);

  // R7: a stalled consumer loses nothing
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && out_valid[0]) |=> out_valid[0]);

endmodule

// File: tb/ds_decode_steer_tb.sv
`timescale 1ns/1ps
module ds_decode_steer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  in_valid = '0;
  logic [8:0]  in_cnt = '0;
  logic [23:0] in_tag = '0;
  logic [1:0]  in_take;
  logic        dec_err;
  logic [2:0]  out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_tag;
  logic [5:0]  out_seq;
  logic [2:0]  out_last;

  ds_decode_steer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cnt(in_cnt),
    .in_tag(in_tag), .in_take(in_take), .dec_err(dec_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_seq(out_seq), .out_last(out_last)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int prog_cnt [256];
  int prog_tag [256];
  int plen = 0, ptr = 0, mcount = 0;
  bit started = 1'b0;
  logic [2:0] vmask = 3'b111;
  int sb_tag [$];
  int sb_seq [$];
  int sb_last [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // monitor: compare removed micro-ops against the scoreboard
  always @(negedge clk) begin
    #1;
    if (started && out_ready) begin
      for (int i = 0; i < 3; i++) begin
        if (out_valid[i]) begin
          if (sb_tag.size() == 0) begin
            check(1'b0, "R9 unexpected micro-op", int'(out_tag[i*8 +: 8]), -1);
          end else begin
            check(int'(out_tag[i*8 +: 8]) == sb_tag[0], "R9 tag order", int'(out_tag[i*8 +: 8]), sb_tag[0]);
            check(int'(out_seq[i*2 +: 2]) == sb_seq[0], "R2 sequence", int'(out_seq[i*2 +: 2]), sb_seq[0]);
            check(int'(out_last[i]) == sb_last[0], "R2 last flag", int'(out_last[i]), sb_last[0]);
            void'(sb_tag.pop_front());
            void'(sb_seq.pop_front());
            void'(sb_last.pop_front());
          end
        end
      end
    end
  end

  task automatic add(input int c);
    prog_cnt[plen] = c;
    prog_tag[plen] = (plen * 7 + 3) % 256;
    plen++;
  endtask

  // driver: one cycle of stimulus plus expected-value computation
  task automatic step(input bit rdy);
    bit v [3];
    int n, u, hc, popn, exp_vis;
    bit bad, open;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      v[k] = (ptr + k < plen) && vmask[k];
      in_valid[k]        = v[k];
      in_cnt[k*3 +: 3]   = v[k] ? 3'(prog_cnt[ptr+k]) : 3'd0;
      in_tag[k*8 +: 8]   = v[k] ? 8'(prog_tag[ptr+k]) : 8'd0;
    end
    out_ready = rdy;
    #1;
    hc  = v[0] ? prog_cnt[ptr] : 0;
    bad = v[0] && (hc == 0 || hc > 4);
    n = 0; u = 0; open = 1'b0;
    if (v[0] && !bad) begin n = 1; u = hc; open = 1'b1; end
    for (int k = 1; k < 3; k++) begin
      if (open && v[k] && prog_cnt[ptr+k] == 1) begin n++; u++; end
      else open = 1'b0;
    end
    if (u > 6 - mcount) begin n = 0; u = 0; end
    check(int'(in_take) == n, "R3/R4/R5/R8 in_take", int'(in_take), n);
    check(dec_err == bad, "R6 dec_err", int'(dec_err), int'(bad));
    exp_vis = (mcount > 3) ? 3 : mcount;
    check($countones(out_valid) == exp_vis, "R7 visible lanes", $countones(out_valid), exp_vis);
    if (n > 0) begin
      for (int j = 0; j < hc; j++) begin
        sb_tag.push_back(prog_tag[ptr]); sb_seq.push_back(j); sb_last.push_back(j == hc - 1);
      end
      for (int k = 1; k < n; k++) begin
        sb_tag.push_back(prog_tag[ptr+k]); sb_seq.push_back(0); sb_last.push_back(1);
      end
    end
    popn = rdy ? exp_vis : 0;
    mcount = mcount + u - popn;
    ptr = ptr + n;
  endtask

  task automatic run(input int mode);
    int s = 0;
    while (ptr < plen && s < 500) begin
      step(mode == 0 ? 1'b1 : (mode == 1 ? (s % 4 == 3) : (s % 2 == 0)));
      s++;
    end
    while (mcount > 0 && s < 1000) begin step(1'b1); s++; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(out_valid == 3'b000, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_take == 2'd0, "R1 in_take idle", int'(in_take), 0);
    check(dec_err == 1'b0, "R1 dec_err idle", int'(dec_err), 0);
    started = 1'b1;

    // R3: all single-micro-op instructions, three per cycle
    for (int i = 0; i < 9; i++) add(1);
    run(0);

    // R2/R3/R4: mixed counts, 4,1,1 is a full six-micro-op group
    add(4); add(1); add(1); add(2); add(1); add(3); add(1); add(1);
    add(1); add(2); add(2); add(4); add(4); add(1); add(0+1); add(3);
    run(0);

    // R5: stalled consumer fills the queue; space check at the edge
    add(3); add(1); add(1); add(2); add(2); add(4); add(1); add(3); add(1);
    add(1); add(1); add(4); add(2);
    run(1);

    // R7/R9: alternating consumer with wrap-around
    for (int i = 0; i < 20; i++) add(1 + (i * 5) % 4);
    run(2);

    // R6: illegal counts held at the head, later slot cut
    add(1); add(1); add(6); add(1);
    step(1'b1);
    repeat (3) step(1'b1);
    prog_cnt[ptr] = 2;
    run(0);
    add(0); add(1);
    repeat (3) step(1'b0);
    prog_cnt[ptr] = 1;
    run(0);
    add(1); add(0); add(1);  // R3: zero count in slot 1 ends group
    run(0);

    // R8: hole in the valid window ends the group
    add(1); add(1); add(1);
    vmask = 3'b101;
    step(1'b1);
    vmask = 3'b111;
    run(0);

    repeat (3) step(1'b1);
    check(sb_tag.size() == 0, "R9 scoreboard drained", sb_tag.size(), 0);
    finish_run();
  end
endmodule